// File: doc/BRIEF.md
# Low-power DDR power-state controller

This block sits between a memory controller core and a low-power DDR device. It puts the device into one of two low-power states and brings it back out. In deep power-down the array loses its contents. The block lowers the clock-enable pin, holds it low, and on exit runs a long recovery wait. It then closes all banks and asks the init sequencer for a complete re-initialization. In clock stop the data is kept. The block parks the device clock with its true phase low and complement phase high, keeps the clock-enable pin high, and on restart needs only a short wait filled with NOP commands.

The core asks for a state by holding a request level high and leaves it by dropping that level. If the request cannot be served yet, it is held pending rather than discarded. A request waits while banks are open, while a burst is still in the pipeline, or while the precharge wait has not elapsed. A busy flag tells the core a request is outstanding or the device is away. A ready flag tells the core when it may issue commands. Outside the low-power states, the core's command bus passes straight through. All waits are parameters given in clock cycles.

Top module: `lpddr_pwr_ctl`

## Requirements
- R1: After reset the block is in the normal state: mem_cke=1, ck_en=1, mem_ready=1, pwr_busy=0, init_req=0, and mem_cmd/mem_a10 equal core_cmd/core_a10. Command encoding {cs_n,ras_n,cas_n,we_n}: NOP=0111, DESELECT=1111, PRECHARGE=0010, power-down entry=0110.
- R2: The deep power-down entry command lasts one cycle: mem_cmd=0110 with mem_cke=0. It is issued only after a cycle in which dpd_req=1, banks_idle=1, burst_active=0 and no precharge is reported. At least T_RP cycles must also have passed since the last pre_issued pulse. A pulse moves the entry to exactly T_RP+1 cycles after the pulse cycle.
- R3: While in deep power-down, mem_cke=0, mem_cmd=DESELECT (1111) and ck_en=1. This state holds for as long as dpd_req stays high.
- R4: After dpd_req falls, the block drives mem_cke=1 with mem_cmd=NOP for exactly T_DPD_WAIT cycles.
- R5: The recovery wait is followed by one cycle of PRECHARGE (0010) with mem_a10=1. After that, init_req is held high until init_done is seen, and the block then returns to the normal state.
- R6: While in clock stop, ck_en=0, mem_cke=1 and mem_cmd=NOP. This state holds for as long as cstop_req stays high.
- R7: Clock stop is not entered while burst_active=1. It is entered in the cycle after burst_active is seen low.
- R8: After cstop_req falls, ck_en=1 and mem_cmd=NOP for exactly T_CS_WAKE cycles. Commands then pass through again.
- R9: A request whose preconditions are unmet stays pending. During that time commands pass through, mem_ready stays 1 and pwr_busy=1. Entry follows as soon as the preconditions hold.
- R10: mem_ready is 0 from the entry cycle until recovery is complete. For deep power-down, recovery ends when init_done is accepted. For clock stop, it ends when the wake wait is over. pwr_busy is 1 whenever mem_ready is 0.
- R11: When dpd_req and cstop_req are both high and both preconditions hold, deep power-down is entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dpd_req | input | 1 | Level request for deep power-down |
| cstop_req | input | 1 | Level request for clock stop |
| banks_idle | input | 1 | All banks are precharged |
| burst_active | input | 1 | A read or write burst is still in the pipeline |
| pre_issued | input | 1 | The core issued a precharge this cycle |
| init_done | input | 1 | The init sequencer has finished re-initialization |
| core_cmd | input | 4 | Core command {cs_n,ras_n,cas_n,we_n} |
| core_a10 | input | 1 | Core address bit 10 |
| mem_cmd | output | 4 | Device command {cs_n,ras_n,cas_n,we_n} |
| mem_a10 | output | 1 | Device address bit 10 |
| mem_cke | output | 1 | Device clock enable |
| ck_en | output | 1 | Clock gate; 0 parks CK low and CK# high |
| init_req | output | 1 | Request for a full re-initialization |
| mem_ready | output | 1 | Core may issue commands |
| pwr_busy | output | 1 | Request pending or device not in the normal state |

## Verification
The precharge-wait window is the hardest case to reach from the ports. It needs a request that arrives in the very cycle of a precharge, while every other precondition already holds. The entry must then land exactly T_RP+1 cycles later, neither earlier nor later. The bench raises pre_issued and dpd_req together and counts the cycles until the entry command appears. The second hard case is the blocked clock stop. The bench holds burst_active high under a standing request, checks that the clock keeps running, and then checks that it parks in the cycle after the burst drains.

// File: rtl/lpddr_pwr_pkg.sv
package lpddr_pwr_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL,
    ST_DPD_ENTER,
    ST_DPD,
    ST_DPD_EXIT,
    ST_PREA,
    ST_INIT,
    ST_CSTOP,
    ST_CS_WAKE
  } pwr_state_t;

  localparam logic [3:0] CMD_NOP      = 4'b0111;
  localparam logic [3:0] CMD_DESELECT = 4'b1111;
  localparam logic [3:0] CMD_PRECHG   = 4'b0010;
  localparam logic [3:0] CMD_DPD      = 4'b0110;
endpackage

// File: rtl/pwr_timer.sv
module pwr_timer #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] load_val,
  output logic             zero
);
  logic [WIDTH-1:0] cnt_q;
  logic [WIDTH-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwr_gate.sv
module pwr_gate (
  input  logic banks_idle,
  input  logic burst_active,
  input  logic pre_issued,
  input  logic trp_zero,
  output logic dpd_ok,
  output logic cs_ok
);
  assign dpd_ok = banks_idle && !burst_active && !pre_issued && trp_zero;
  assign cs_ok  = !burst_active;
endmodule

// File: rtl/lpddr_pwr_ctl.sv
module lpddr_pwr_ctl
  import lpddr_pwr_pkg::*;
#(
  parameter int T_RP       = 3,
  parameter int T_DPD_WAIT = 40,
  parameter int T_CS_WAKE  = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dpd_req,
  input  logic       cstop_req,
  input  logic       banks_idle,
  input  logic       burst_active,
  input  logic       pre_issued,
  input  logic       init_done,
  input  logic [3:0] core_cmd,
  input  logic       core_a10,
  output logic [3:0] mem_cmd,
  output logic       mem_a10,
  output logic       mem_cke,
  output logic       ck_en,
  output logic       init_req,
  output logic       mem_ready,
  output logic       pwr_busy
);
  localparam int REC_MAX = (T_DPD_WAIT > T_CS_WAKE) ? T_DPD_WAIT : T_CS_WAKE;
  localparam int REC_W   = $clog2(REC_MAX + 1);
  localparam int RP_W    = $clog2(T_RP + 1);

  pwr_state_t       state_q, state_d;
  logic             trp_zero, rec_zero;
  logic             dpd_ok, cs_ok;
  logic             rec_load;
  logic [REC_W-1:0] rec_val;

  pwr_gate u_gate (
    .banks_idle   (banks_idle),
    .burst_active (burst_active),
    .pre_issued   (pre_issued),
    .trp_zero     (trp_zero),
    .dpd_ok       (dpd_ok),
    .cs_ok        (cs_ok)
  );

  pwr_timer #(.WIDTH(RP_W)) u_trp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (pre_issued),
    .load_val (RP_W'(T_RP - 1)),
    .zero     (trp_zero)
  );

  always_comb begin
    rec_load = ((state_q == ST_DPD) && !dpd_req) ||
               ((state_q == ST_CSTOP) && !cstop_req);
    rec_val  = (state_q == ST_DPD) ? REC_W'(T_DPD_WAIT - 1) : REC_W'(T_CS_WAKE - 1);
  end

  pwr_timer #(.WIDTH(REC_W)) u_rec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (rec_load),
    .load_val (rec_val),
    .zero     (rec_zero)
  );

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: begin
        if (dpd_req && dpd_ok)          state_d = ST_DPD_ENTER;
        else if (cstop_req && cs_ok)    state_d = ST_CSTOP;
      end
      ST_DPD_ENTER:                     state_d = ST_DPD;
      ST_DPD:      if (!dpd_req)        state_d = ST_DPD_EXIT;
      ST_DPD_EXIT: if (rec_zero)        state_d = ST_PREA;
      ST_PREA:                          state_d = ST_INIT;
      ST_INIT:     if (init_done)       state_d = ST_NORMAL;
      ST_CSTOP:    if (!cstop_req)      state_d = ST_CS_WAKE;
      ST_CS_WAKE:  if (rec_zero)        state_d = ST_NORMAL;
      default:                          state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_NORMAL;
    else        state_q <= state_d;
  end

  // output decode
  always_comb begin
    mem_cmd  = CMD_NOP;
    mem_a10  = 1'b0;
    mem_cke  = 1'b1;
    ck_en    = 1'b1;
    init_req = 1'b0;
    unique case (state_q)
      ST_NORMAL: begin
        mem_cmd = core_cmd;
        mem_a10 = core_a10;
      end
      ST_DPD_ENTER: begin
        mem_cmd = CMD_DPD;
        mem_cke = 1'b0;
      end
      ST_DPD: begin
        mem_cmd = CMD_DESELECT;
        mem_cke = 1'b0;
      end
      ST_PREA: begin
        mem_cmd = CMD_PRECHG;
        mem_a10 = 1'b1;
      end
      ST_INIT:  init_req = 1'b1;
      ST_CSTOP: ck_en    = 1'b0;
      default: ;
    endcase
  end

  assign mem_ready = (state_q == ST_NORMAL);
  assign pwr_busy  = (state_q != ST_NORMAL) || dpd_req || cstop_req;
endmodule

// File: rtl/lpddr_pwr_ctl_chk.sv
module lpddr_pwr_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dpd_req,
  input logic       burst_active,
  input logic       banks_idle,
  input logic [3:0] mem_cmd,
  input logic       mem_cke,
  input logic       ck_en,
  input logic       mem_ready,
  input logic       pwr_busy
);
  p_dpd_entry_safe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cmd == 4'b0110 && !mem_cke) |-> $past(banks_idle && !burst_active && dpd_req));

  p_cke_fall_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cke) |-> (mem_cmd == 4'b0110));

  p_dpd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cke && $past(!mem_cke)) |-> (mem_cmd == 4'b1111 && ck_en));

  p_cke_rise_nop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_cke) |-> (mem_cmd == 4'b0111 && !mem_ready));

  p_cstop_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ck_en |-> (mem_cke && mem_cmd == 4'b0111));

  p_cstop_drained_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ck_en) |-> $past(!burst_active));

  p_wake_nop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ck_en) |-> (mem_cmd == 4'b0111 && !mem_ready));

  p_busy_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ready |-> pwr_busy);
endmodule

bind lpddr_pwr_ctl lpddr_pwr_ctl_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .dpd_req      (dpd_req),
  .burst_active (burst_active),
  .banks_idle   (banks_idle),
  .mem_cmd      (mem_cmd),
  .mem_cke      (mem_cke),
  .ck_en        (ck_en),
  .mem_ready    (mem_ready),
  .pwr_busy     (pwr_busy)
);

// File: tb/sim_lpddr_pwr_ctl.sv
module sim_lpddr_pwr_ctl;
  localparam int CLK_PERIOD = 10;
  localparam int P_RP   = 3;
  localparam int P_DPD  = 40;
  localparam int P_WAKE = 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dpd_req = 1'b0, cstop_req = 1'b0;
  logic       banks_idle = 1'b1, burst_active = 1'b0, pre_issued = 1'b0, init_done = 1'b0;
  logic [3:0] core_cmd = 4'b0101;
  logic       core_a10 = 1'b0;
  logic [3:0] mem_cmd;
  logic       mem_a10, mem_cke, ck_en, init_req, mem_ready, pwr_busy;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpddr_pwr_ctl #(.T_RP(P_RP), .T_DPD_WAIT(P_DPD), .T_CS_WAKE(P_WAKE)) u0 (
    .clk(clk), .rst_n(rst_n), .dpd_req(dpd_req), .cstop_req(cstop_req),
    .banks_idle(banks_idle), .burst_active(burst_active), .pre_issued(pre_issued),
    .init_done(init_done), .core_cmd(core_cmd), .core_a10(core_a10),
    .mem_cmd(mem_cmd), .mem_a10(mem_a10), .mem_cke(mem_cke), .ck_en(ck_en),
    .init_req(init_req), .mem_ready(mem_ready), .pwr_busy(pwr_busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    check(mem_cke && ck_en && mem_ready && !pwr_busy && !init_req, "R1 idle flags",
          {mem_cke, ck_en, mem_ready, pwr_busy, init_req}, 5'b11100);
    check(mem_cmd == core_cmd, "R1 passthrough", mem_cmd, core_cmd);
  endtask

  task automatic t_dpd_blocked();
    banks_idle = 1'b0;
    dpd_req = 1'b1;
    repeat (4) step();
    check(mem_cke && mem_ready && mem_cmd == core_cmd, "R9 pending passthrough",
          {mem_cke, mem_ready, mem_cmd}, {2'b11, core_cmd});
    check(pwr_busy, "R9 busy while pending", pwr_busy, 1);
    banks_idle = 1'b1;
    step();
    check(mem_cmd == 4'b0110 && !mem_cke, "R2 entry after banks idle",
          {mem_cke, mem_cmd}, 5'b00110);
    check(!mem_ready, "R10 ready low at entry", mem_ready, 0);
  endtask

  task automatic t_dpd_hold_exit();
    step();
    repeat (5) begin
      check(!mem_cke && mem_cmd == 4'b1111 && ck_en, "R3 held in power-down",
            {mem_cke, ck_en, mem_cmd}, 6'b011111);
      step();
    end
    dpd_req = 1'b0;
    begin
      int n = 0;
      step();
      while (mem_cke && mem_cmd == 4'b0111 && !mem_ready && n < 200) begin
        n++;
        step();
      end
      check(n == P_DPD, "R4 recovery NOP cycles", n, P_DPD);
    end
    check(mem_cmd == 4'b0010 && mem_a10 && mem_cke, "R5 precharge all",
          {mem_a10, mem_cmd}, 5'b10010);
    step();
    repeat (3) begin
      check(init_req && !mem_ready, "R5 init request held", {init_req, mem_ready}, 2'b10);
      step();
    end
    init_done = 1'b1;
    step();
    init_done = 1'b0;
    check(!init_req && mem_ready && mem_cmd == core_cmd, "R10 ready after init",
          {init_req, mem_ready}, 2'b01);
    check(!pwr_busy, "R10 busy cleared", pwr_busy, 0);
  endtask

  task automatic t_trp_window();
    int n = 0;
    pre_issued = 1'b1;
    dpd_req = 1'b1;
    step();
    pre_issued = 1'b0;
    n = 1;
    while (!(mem_cmd == 4'b0110 && !mem_cke) && n < 20) begin
      step();
      n++;
    end
    check(n == P_RP + 1, "R2 precharge wait", n, P_RP + 1);
    dpd_req = 1'b0;
    while (!init_req && n < 200) begin
      step();
      n++;
    end
    init_done = 1'b1;
    step();
    init_done = 1'b0;
    check(mem_ready, "R5 back to normal", mem_ready, 1);
  endtask

  task automatic t_cstop();
    burst_active = 1'b1;
    cstop_req = 1'b1;
    repeat (3) step();
    check(ck_en && mem_ready && pwr_busy, "R7 no stop during burst",
          {ck_en, mem_ready, pwr_busy}, 3'b111);
    burst_active = 1'b0;
    step();
    check(!ck_en && mem_cke && mem_cmd == 4'b0111, "R7 stop after drain",
          {ck_en, mem_cke, mem_cmd}, 6'b010111);
    repeat (4) step();
    check(!ck_en && mem_cke && mem_cmd == 4'b0111 && !mem_ready, "R6 clock parked",
          {ck_en, mem_cke, mem_ready}, 3'b010);
    cstop_req = 1'b0;
    begin
      int n = 0;
      step();
      while (ck_en && mem_cmd == 4'b0111 && !mem_ready && n < 20) begin
        n++;
        step();
      end
      check(n == P_WAKE, "R8 wake NOP cycles", n, P_WAKE);
    end
    check(mem_ready && mem_cmd == core_cmd && ck_en, "R8 passthrough after wake",
          {mem_ready, mem_cmd}, {1'b1, core_cmd});
  endtask

  task automatic t_priority();
    dpd_req = 1'b1;
    cstop_req = 1'b1;
    step();
    check(mem_cmd == 4'b0110 && !mem_cke && ck_en, "R11 power-down wins",
          {ck_en, mem_cke, mem_cmd}, 6'b100110);
    dpd_req = 1'b0;
    cstop_req = 1'b0;
    repeat (P_DPD + 4) step();
    init_done = 1'b1;
    step();
    init_done = 1'b0;
    check(mem_ready, "R11 recovered", mem_ready, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step();
    t_reset();
    t_dpd_blocked();
    t_dpd_hold_exit();
    t_trp_window();
    t_cstop();
    t_priority();
    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule